// File: doc/BRIEF.md
# Network Status LED Driver

This block turns the raw status signals of a 10/100 Ethernet transceiver into five active-low LED lines. The lines are duplex or polarity, collision, link or traffic, receive and transmit. An LED lights when its line is driven 0.

Activity on receive and transmit usually arrives as very short pulses. Each of these two pulses feeds a monostable stretcher, so the LED stays on long enough to be seen. Two mode bits change the meaning of two pins:
- **Traffic mode** turns the link LED into a traffic LED. It stays on while the link is good and flashes while stretched activity is present.
- **Polarity mode** makes the duplex LED show the receive polarity instead of the duplex state.

All timing runs from one free-running clock. A divider produces a time-base tick every `TICK_DIV` clock cycles, and the tick counter starts from 0 at reset. The stretch length and the flash half-period are counted in these ticks.

The receive/transmit stretcher has two states:
- `STR_IDLE` goes to `STR_HOLD` on a trigger pulse.
- `STR_HOLD` reloads its counter on every new trigger.
- `STR_HOLD` returns to `STR_IDLE` on the tick that finds one tick remaining.

The traffic state machine has four states:
- Any state goes to `TRF_DOWN` when the link is bad.
- With traffic mode off and the link good, any state goes to `TRF_STEADY`.
- In traffic mode, `TRF_DOWN` goes to `TRF_STEADY`.
- `TRF_STEADY` goes to `TRF_FLASH_OFF` when activity is present, loading the half-period counter.
- `TRF_FLASH_OFF` goes to `TRF_FLASH_ON` when its half-period expires.
- When the half-period of `TRF_FLASH_ON` expires, it goes back to `TRF_FLASH_OFF` if activity is still present. Otherwise it goes to `TRF_STEADY`.

The LED is lit in `TRF_STEADY` and in `TRF_FLASH_ON`.

Top module: `net_led_driver`

## Requirements
- R1: After reset, with all inputs low, every LED line is high (off). Every LED line is driven 0 to light the LED and 1 to turn it off.
- R2: A receive pulse sampled at a clock edge lights the receive LED from that edge on. The LED stays lit until `STRETCH_TICKS` time-base ticks have been counted after the last pulse, and a new pulse restarts that count. Ticks occur on cycles `TICK_DIV-1`, `2*TICK_DIV-1`, and so on, counted after reset is released.
- R3: The transmit LED behaves as R2 does, but is driven by transmit pulses only. It is independent of the receive LED.
- R4: With the traffic-mode bit at 0, the link LED is lit exactly when link-good is 1.
- R5: With the traffic-mode bit at 1 and link-good at 0, the link LED is off whatever the activity. From the edge that samples link-good at 0, the state machine is in `TRF_DOWN`.
- R6: With the traffic-mode bit at 1, the link LED is lit steadily in the following case:
  - the link has been good for at least one clock edge, and
  - neither the receive nor the transmit stretch is active.
- R7: In traffic mode with a good link, stretched activity (receive or transmit LED lit) flashes the link LED in a repeating cycle:
  - The LED is forced off starting at the edge after activity is seen in `TRF_STEADY`, for `BLINK_HALF` ticks.
  - It is then on for `BLINK_HALF` ticks.
  - The off/on cycle repeats while activity remains, and the LED returns to steady on once activity ends.
- R8: With the polarity-mode bit at 0, the duplex LED is lit exactly when full-duplex is 1.
- R9: With the polarity-mode bit at 1, the duplex LED is lit exactly when polarity-inverted is 1.
- R10: The collision LED is lit while collision is 1 and full-duplex is 0. In full duplex it is held off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Synchronous reset, active low |
| link_good | input | 1 | Link is up |
| full_duplex | input | 1 | Link runs full duplex |
| pol_inverted | input | 1 | Receive polarity is inverted |
| collision | input | 1 | Collision in progress |
| tx_pulse | input | 1 | Transmit activity pulse |
| rx_pulse | input | 1 | Receive activity pulse |
| traffic_mode | input | 1 | 1: link LED acts as traffic LED |
| polarity_mode | input | 1 | 1: duplex LED shows polarity |
| led_dup_n | output | 1 | Duplex/polarity LED, active low |
| led_col_n | output | 1 | Collision LED, active low |
| led_link_n | output | 1 | Link/traffic LED, active low |
| led_rx_n | output | 1 | Receive LED, active low |
| led_tx_n | output | 1 | Transmit LED, active low |

## Verification
On every cycle, the assertions check the following:
- the spacing of time-base ticks;
- that a trigger lights and fully reloads its stretcher;
- that a held stretch is not released between ticks;
- that a bad link forces `TRF_DOWN`;
- that idle traffic mode holds `TRF_STEADY`;
- that activity starts a flash with a full half-period loaded.

The following can only be shown by the bench scenarios, which compare every LED against a tick-counting model at each cycle:
- the total on-time of a stretch after its last pulse;
- the off/on durations of the flash and the return to steady light;
- how the mode bits remap the duplex and link pins;
- that the collision LED is held off in full duplex.

// File: rtl/led_status_pkg.sv
package led_status_pkg;

    typedef enum logic {
        STR_IDLE = 1'b0,
        STR_HOLD = 1'b1
    } stretch_state_e;

    typedef enum logic [1:0] {
        TRF_DOWN      = 2'd0,
        TRF_STEADY    = 2'd1,
        TRF_FLASH_OFF = 2'd2,
        TRF_FLASH_ON  = 2'd3
    } traffic_state_e;

endpackage

// File: rtl/led_tick_gen.sv
module led_tick_gen #(
    parameter int unsigned TICK_DIV = 50000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    always_comb begin
        tick = (cnt_q == LAST);
    end

    generate
        if (TICK_DIV > 1) begin : g_gap_check
            // time base behind R2 / R3: ticks never come back to back
            assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/led_pulse_stretch.sv
module led_pulse_stretch
    import led_status_pkg::*;
#(
    parameter int unsigned STRETCH_TICKS = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic trigger,
    output logic lit
);
    localparam int unsigned RW = $clog2(STRETCH_TICKS + 1);
    localparam logic [RW-1:0] FULL = RW'(STRETCH_TICKS);
    localparam logic [RW-1:0] ONE  = RW'(1);

    stretch_state_e state_q, state_d;
    logic [RW-1:0]  rem_q, rem_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= STR_IDLE;
            rem_q   <= '0;
        end else begin
            state_q <= state_d;
            rem_q   <= rem_d;
        end
    end

    always_comb begin
        state_d = state_q;
        rem_d   = rem_q;
        unique case (state_q)
            STR_IDLE: begin
                if (trigger) begin
                    state_d = STR_HOLD;
                    rem_d   = FULL;
                end
            end
            STR_HOLD: begin
                if (trigger) begin
                    rem_d = FULL;
                end else if (tick) begin
                    if (rem_q == ONE) begin
                        state_d = STR_IDLE;
                        rem_d   = '0;
                    end else begin
                        rem_d = rem_q - ONE;
                    end
                end
            end
        endcase
    end

    always_comb begin
        lit = (state_q == STR_HOLD);
    end

    // R2 and R3 share this stretcher
    assert_trigger_lights_R2: assert property (@(posedge clk) disable iff (!rst_n)
        trigger |=> (lit && rem_q == FULL));

    assert_no_early_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (lit && !tick) |=> lit);

    assert_count_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lit |-> (rem_q != '0 && rem_q <= FULL));

endmodule

// File: rtl/led_traffic_fsm.sv
module led_traffic_fsm
    import led_status_pkg::*;
#(
    parameter int unsigned BLINK_HALF = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic traffic_mode,
    input  logic link_up,
    input  logic activity,
    output logic link_lit
);
    localparam int unsigned HW = $clog2(BLINK_HALF + 1);
    localparam logic [HW-1:0] HALF = HW'(BLINK_HALF);
    localparam logic [HW-1:0] ONE  = HW'(1);

    traffic_state_e state_q, state_d;
    logic [HW-1:0]  half_q, half_d;
    logic           expire;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TRF_DOWN;
            half_q  <= '0;
        end else begin
            state_q <= state_d;
            half_q  <= half_d;
        end
    end

    always_comb begin
        expire  = tick && (half_q == ONE);
        state_d = state_q;
        half_d  = half_q;
        if (!link_up) begin
            state_d = TRF_DOWN;
            half_d  = '0;
        end else if (!traffic_mode) begin
            state_d = TRF_STEADY;
            half_d  = '0;
        end else begin
            unique case (state_q)
                TRF_DOWN: begin
                    state_d = TRF_STEADY;
                end
                TRF_STEADY: begin
                    if (activity) begin
                        state_d = TRF_FLASH_OFF;
                        half_d  = HALF;
                    end
                end
                TRF_FLASH_OFF: begin
                    if (expire) begin
                        state_d = TRF_FLASH_ON;
                        half_d  = HALF;
                    end else if (tick) begin
                        half_d = half_q - ONE;
                    end
                end
                TRF_FLASH_ON: begin
                    if (expire) begin
                        if (activity) begin
                            state_d = TRF_FLASH_OFF;
                            half_d  = HALF;
                        end else begin
                            state_d = TRF_STEADY;
                            half_d  = '0;
                        end
                    end else if (tick) begin
                        half_d = half_q - ONE;
                    end
                end
            endcase
        end
    end

    always_comb begin
        if (traffic_mode) begin
            link_lit = (state_q == TRF_STEADY) || (state_q == TRF_FLASH_ON);
        end else begin
            link_lit = link_up;
        end
    end

    assert_link_down_dark_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !link_up |=> (state_q == TRF_DOWN));

    assert_steady_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (traffic_mode && link_up && state_q == TRF_STEADY && !activity)
        |=> (state_q == TRF_STEADY));

    assert_flash_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (traffic_mode && link_up && state_q == TRF_STEADY && activity)
        |=> (state_q == TRF_FLASH_OFF && half_q == HALF));

    assert_half_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TRF_FLASH_OFF || state_q == TRF_FLASH_ON)
        |-> (half_q != '0 && half_q <= HALF));

endmodule

// File: rtl/net_led_driver.sv
module net_led_driver #(
    parameter int unsigned TICK_DIV      = 50000,
    parameter int unsigned STRETCH_TICKS = 50,
    parameter int unsigned BLINK_HALF    = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic link_good,
    input  logic full_duplex,
    input  logic pol_inverted,
    input  logic collision,
    input  logic tx_pulse,
    input  logic rx_pulse,
    input  logic traffic_mode,
    input  logic polarity_mode,
    output logic led_dup_n,
    output logic led_col_n,
    output logic led_link_n,
    output logic led_rx_n,
    output logic led_tx_n
);
    localparam int unsigned NCH = 2;
    localparam int unsigned CH_RX = 0;
    localparam int unsigned CH_TX = 1;

    logic           tick;
    logic [NCH-1:0] trig;
    logic [NCH-1:0] stretched;
    logic           link_lit;

    led_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    always_comb begin
        trig[CH_RX] = rx_pulse;
        trig[CH_TX] = tx_pulse;
    end

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_stretch
            led_pulse_stretch #(.STRETCH_TICKS(STRETCH_TICKS)) u_str (
                .clk     (clk),
                .rst_n   (rst_n),
                .tick    (tick),
                .trigger (trig[g]),
                .lit     (stretched[g])
            );
        end
    endgenerate

    led_traffic_fsm #(.BLINK_HALF(BLINK_HALF)) u_traffic (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .traffic_mode (traffic_mode),
        .link_up      (link_good),
        .activity     (|stretched),
        .link_lit     (link_lit)
    );

    always_comb begin
        led_rx_n   = ~stretched[CH_RX];
        led_tx_n   = ~stretched[CH_TX];
        led_link_n = ~link_lit;
        led_dup_n  = polarity_mode ? ~pol_inverted : ~full_duplex;
        led_col_n  = ~(collision & ~full_duplex);
    end

endmodule

// File: tb/net_led_driver_tb.sv
module net_led_driver_tb;
    localparam int TD = 4;
    localparam int ST = 5;
    localparam int BH = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic link_good = 0, full_duplex = 0, pol_inverted = 0, collision = 0;
    logic tx_pulse = 0, rx_pulse = 0, traffic_mode = 0, polarity_mode = 0;
    logic led_dup_n, led_col_n, led_link_n, led_rx_n, led_tx_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    net_led_driver #(.TICK_DIV(TD), .STRETCH_TICKS(ST), .BLINK_HALF(BH)) u_dut (
        .clk(clk), .rst_n(rst_n), .link_good(link_good), .full_duplex(full_duplex),
        .pol_inverted(pol_inverted), .collision(collision), .tx_pulse(tx_pulse),
        .rx_pulse(rx_pulse), .traffic_mode(traffic_mode), .polarity_mode(polarity_mode),
        .led_dup_n(led_dup_n), .led_col_n(led_col_n), .led_link_n(led_link_n),
        .led_rx_n(led_rx_n), .led_tx_n(led_tx_n)
    );

    // expected-behaviour model built from the requirements
    int m_cnt, m_rx_rem, m_tx_rem, m_half, m_st;
    bit m_rx, m_tx, t_now, act_now;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt <= 0; m_rx <= 0; m_tx <= 0; m_rx_rem <= 0; m_tx_rem <= 0;
            m_st <= 0; m_half <= 0;
        end else begin
            t_now   = (m_cnt == TD - 1);
            act_now = m_rx | m_tx;
            m_cnt  <= t_now ? 0 : m_cnt + 1;
            if (rx_pulse) begin m_rx <= 1; m_rx_rem <= ST; end
            else if (m_rx && t_now) begin
                if (m_rx_rem == 1) m_rx <= 0;
                m_rx_rem <= m_rx_rem - 1;
            end
            if (tx_pulse) begin m_tx <= 1; m_tx_rem <= ST; end
            else if (m_tx && t_now) begin
                if (m_tx_rem == 1) m_tx <= 0;
                m_tx_rem <= m_tx_rem - 1;
            end
            if (!link_good) m_st <= 0;
            else if (!traffic_mode) m_st <= 1;
            else case (m_st)
                0: m_st <= 1;
                1: if (act_now) begin m_st <= 2; m_half <= BH; end
                2: if (t_now) begin
                       if (m_half == 1) begin m_st <= 3; m_half <= BH; end
                       else m_half <= m_half - 1;
                   end
                default: if (t_now) begin
                       if (m_half == 1) begin
                           if (act_now) begin m_st <= 2; m_half <= BH; end
                           else m_st <= 1;
                       end else m_half <= m_half - 1;
                   end
            endcase
        end
    end

    task automatic chk(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic check_all();
        logic e_link;
        string ltag;
        e_link = traffic_mode ? !(m_st == 1 || m_st == 3) : !link_good;
        if (!traffic_mode) ltag = "R4 link LED";
        else if (!link_good) ltag = "R5 link LED";
        else if (m_st == 2 || m_st == 3) ltag = "R7 link LED";
        else ltag = "R6 link LED";
        chk("R2 rx LED", led_rx_n, !m_rx);
        chk("R3 tx LED", led_tx_n, !m_tx);
        chk(ltag, led_link_n, e_link);
        chk(polarity_mode ? "R9 dup LED" : "R8 dup LED", led_dup_n,
            polarity_mode ? !pol_inverted : !full_duplex);
        chk("R10 col LED", led_col_n, !(collision && !full_duplex));
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #5;
            check_all();
            rx_pulse = 0; tx_pulse = 0;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #5 rst_n = 1;
        // R1 reset state
        chk("R1 rx", led_rx_n, 1'b1); chk("R1 tx", led_tx_n, 1'b1);
        chk("R1 link", led_link_n, 1'b1); chk("R1 dup", led_dup_n, 1'b1);
        chk("R1 col", led_col_n, 1'b1);
        step(3);
        // R4 plain link
        link_good = 1; step(4);
        // R2 single-cycle pulse, full stretch
        rx_pulse = 1; step(1); step(30);
        // R3 retrigger during stretch
        tx_pulse = 1; step(10); tx_pulse = 1; step(1); step(30);
        // R7 traffic flashing under dense activity, then R6 steady
        traffic_mode = 1;
        for (int k = 0; k < 12; k++) begin rx_pulse = 1; step(1); step(7); end
        step(60);
        // R5 link down while active
        tx_pulse = 1; step(3); link_good = 0; step(10); tx_pulse = 1; step(20);
        link_good = 1; step(5);
        // R8 / R9 / R10
        full_duplex = 1; collision = 1; step(3);
        polarity_mode = 1; pol_inverted = 1; step(3);
        full_duplex = 0; step(3); pol_inverted = 0; step(3);
        // random phase
        void'($urandom(32'd20240611));
        for (int c = 0; c < 4000; c++) begin
            rx_pulse = ($urandom % 25) == 0;
            tx_pulse = ($urandom % 30) == 0;
            collision = ($urandom % 6) == 0;
            if ((c % 150) == 0) begin
                link_good     = ($urandom % 4) != 0;
                traffic_mode  = $urandom % 2;
                polarity_mode = $urandom % 2;
                full_duplex   = $urandom % 2;
                pol_inverted  = $urandom % 2;
            end
            @(posedge clk); #5;
            check_all();
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule